// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers of a processor core whose register view depends on the current 5-bit operating mode. Some architectural indices are backed by several physical copies, and the mode decides which copy a read or write reaches. Changing mode swaps the visible copies in one clock edge, and every copy keeps its contents while it is hidden, so a return to a mode shows exactly what that mode left behind.

Beside the general registers the block keeps one saved-status word for each exception mode. It offers two combinational read ports, one synchronous write port, a mode-change request that carries the new mode value, and a read and write path to the saved-status word of the current mode. Exception entry, program counter stepping and memory access belong to the surrounding core.

Top module: `rbank_file`

## Requirements
- R1: After a synchronous active-low reset, every general register and every saved-status word reads zero and `mode_cur` is 0x13 (supervisor).
- R2: With `mode_chg` high at a clock edge, `mode_cur` takes `mode_new` at that edge and reads in the next cycle see the new mode's copies; with `mode_chg` low, `mode_cur` holds. Valid modes: user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F.
- R3: Indices 0 to 7 and 15 are a single set seen identically from every mode.
- R4: Fast interrupt mode (0x11) has private copies of indices 8 to 14; writes there are invisible from any other mode.
- R5: Interrupt, supervisor, abort and undefined modes each have private copies of indices 13 and 14 only; indices 8 to 12 in these modes are the set shared with user mode.
- R6: User (0x10) and system (0x1F) modes see one common set of indices 8 to 14.
- R7: Each of the five exception modes owns a saved-status word; `saved_wr_en` writes the word of the current mode at the edge and `saved_rd_data` shows that word combinationally.
- R8: In user or system mode `saved_rd_data` is zero and a saved-status write changes no word.
- R9: A mode value outside the valid list is held in `mode_cur` as given but selects the user copies, with saved-status reading zero.
- R10: A general or saved-status write in the same cycle as a mode change lands in the copy of the mode in force before the change.
- R11: Every copy keeps its contents across any number of mode changes.
- R12: Both read ports are combinational and independent; a write becomes visible on them only after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| mode_chg | input | 1 | Mode change request |
| mode_new | input | 5 | Mode taken on a change request |
| mode_cur | output | 5 | Current mode value |
| saved_wr_en | input | 1 | Saved-status write enable for the current mode |
| saved_wr_data | input | 32 | Saved-status write data |
| saved_rd_data | output | 32 | Saved-status word of the current mode |

## Verification
Read data depends combinationally on the index and the registered mode, so the bench compares it in the same cycle it sets an index, well clear of any edge. A write or a mode change commits at the next rising edge and is looked for one time unit after it; for the visibility rule the read port is also sampled before that edge to see the old value. Same-cycle write and mode change cases are checked by visiting both the old and new mode afterwards.

// File: rtl/rbank_pkg.sv
// Shared mode encodings, bank identifiers and the mode-to-bank mapping.
// Assumes a 5-bit mode field; any unlisted value maps to the user bank.
package rbank_pkg;

    localparam logic [4:0] MODE_USER    = 5'h10;
    localparam logic [4:0] MODE_FASTIRQ = 5'h11;
    localparam logic [4:0] MODE_IRQ     = 5'h12;
    localparam logic [4:0] MODE_SUPER   = 5'h13;
    localparam logic [4:0] MODE_ABORT   = 5'h17;
    localparam logic [4:0] MODE_UNDEF   = 5'h1B;
    localparam logic [4:0] MODE_SYSTEM  = 5'h1F;

    // Banks from IRQ upward own only the upper pair of registers.
    typedef enum logic [2:0] {
        BK_USER = 3'd0,
        BK_FAST = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SUP  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

    typedef enum logic [1:0] {
        LOC_SHARED = 2'd0,
        LOC_FAST   = 2'd1,
        LOC_PRIV   = 2'd2
    } loc_e;

    localparam int NUM_PRIV_BANKS = 4;
    localparam int NUM_SAVED      = 5;

    function automatic bank_e mode_to_bank(input logic [4:0] m);
        case (m)
            MODE_FASTIRQ: return BK_FAST;
            MODE_IRQ:     return BK_IRQ;
            MODE_SUPER:   return BK_SUP;
            MODE_ABORT:   return BK_ABT;
            MODE_UNDEF:   return BK_UND;
            default:      return BK_USER;
        endcase
    endfunction

endpackage

// File: rtl/rbank_mode_ctl.sv
// Holds the current mode value and decodes it to a bank identifier.
// Assumes mode_new is only sampled when mode_chg is high.
module rbank_mode_ctl
    import rbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_chg,
    input  logic [4:0] mode_new,
    output logic [4:0] mode_q,
    output bank_e      bank
);

    // Mode register: supervisor after reset, reloaded on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= MODE_SUPER;
        else if (mode_chg) mode_q <= mode_new;
    end

    // Bank decode of the registered mode.
    always_comb bank = mode_to_bank(mode_q);

    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (mode_q == $past(mode_new)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chg |=> $stable(mode_q));

endmodule

// File: rtl/rbank_gpr.sv
// General register storage: one shared set, a fast-interrupt set for the
// middle-to-upper indices and a private upper pair per exception bank.
// Assumes the bank input is stable between clock edges.
module rbank_gpr
    import rbank_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int FAST_LO  = 8,
    parameter int PRIV_LO  = 13,
    parameter int TOP_IDX  = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  bank_e                       bank,
    input  logic [$clog2(NUM_REGS)-1:0] rd_a_idx,
    output logic [DATA_W-1:0]           rd_a_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_b_idx,
    output logic [DATA_W-1:0]           rd_b_data,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]           wr_data
);

    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int FAST_CNT = TOP_IDX - FAST_LO + 1;
    localparam int PRIV_CNT = TOP_IDX - PRIV_LO + 1;
    localparam int FSLOT_W  = $clog2(FAST_CNT);
    localparam int PSLOT_W  = (PRIV_CNT > 1) ? $clog2(PRIV_CNT) : 1;
    localparam int PB_W     = $clog2(NUM_PRIV_BANKS);
    localparam logic [IDX_W-1:0] FAST_LO_I = IDX_W'(FAST_LO);
    localparam logic [IDX_W-1:0] PRIV_LO_I = IDX_W'(PRIV_LO);
    localparam logic [IDX_W-1:0] TOP_I     = IDX_W'(TOP_IDX);

    logic [DATA_W-1:0] shared_q [NUM_REGS];
    logic [DATA_W-1:0] fast_q   [FAST_CNT];
    logic [DATA_W-1:0] priv_q   [NUM_PRIV_BANKS][PRIV_CNT];

    function automatic loc_e loc_of(input logic [IDX_W-1:0] idx, input bank_e bk);
        if (bk == BK_FAST && idx >= FAST_LO_I && idx <= TOP_I) return LOC_FAST;
        if (bk >= BK_IRQ  && idx >= PRIV_LO_I && idx <= TOP_I) return LOC_PRIV;
        return LOC_SHARED;
    endfunction

    function automatic logic [FSLOT_W-1:0] fslot(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] off;
        off = idx - FAST_LO_I;
        return off[FSLOT_W-1:0];
    endfunction

    function automatic logic [PSLOT_W-1:0] pslot(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] off;
        off = idx - PRIV_LO_I;
        return off[PSLOT_W-1:0];
    endfunction

    function automatic logic [PB_W-1:0] pbank(input bank_e bk);
        logic [2:0] d;
        d = 3'(bk) - 3'(BK_IRQ);
        return d[PB_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] fetch(input logic [IDX_W-1:0] idx, input bank_e bk);
        case (loc_of(idx, bk))
            LOC_FAST: return fast_q[fslot(idx)];
            LOC_PRIV: return priv_q[pbank(bk)][pslot(idx)];
            default:  return shared_q[idx];
        endcase
    endfunction

    loc_e             wr_loc;
    logic [FSLOT_W-1:0] wr_fslot;
    logic [PSLOT_W-1:0] wr_pslot;
    logic [PB_W-1:0]    wr_pbank;

    // Write target decode for the bank in force this cycle.
    always_comb begin
        wr_loc   = loc_of(wr_idx, bank);
        wr_fslot = fslot(wr_idx);
        wr_pslot = pslot(wr_idx);
        wr_pbank = pbank(bank);
    end

    genvar gi, gj;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_shared
            // Shared register gi: cleared on reset, loaded when targeted.
            always_ff @(posedge clk) begin
                if (!rst_n) shared_q[gi] <= '0;
                else if (wr_en && wr_loc == LOC_SHARED && wr_idx == IDX_W'(gi))
                    shared_q[gi] <= wr_data;
            end
        end
        for (gi = 0; gi < FAST_CNT; gi++) begin : g_fast
            // Fast-interrupt copy gi: cleared on reset, loaded when targeted.
            always_ff @(posedge clk) begin
                if (!rst_n) fast_q[gi] <= '0;
                else if (wr_en && wr_loc == LOC_FAST && wr_fslot == FSLOT_W'(gi))
                    fast_q[gi] <= wr_data;
            end
        end
        for (gi = 0; gi < NUM_PRIV_BANKS; gi++) begin : g_pbank
            for (gj = 0; gj < PRIV_CNT; gj++) begin : g_pslot
                // Private copy gj of exception bank gi.
                always_ff @(posedge clk) begin
                    if (!rst_n) priv_q[gi][gj] <= '0;
                    else if (wr_en && wr_loc == LOC_PRIV &&
                             wr_pbank == PB_W'(gi) && wr_pslot == PSLOT_W'(gj))
                        priv_q[gi][gj] <= wr_data;
                end
            end
        end
    endgenerate

    // Combinational read ports.
    always_comb begin
        rd_a_data = fetch(rd_a_idx, bank);
        rd_b_data = fetch(rd_b_idx, bank);
    end

    // Marks cycles whose previous cycle was out of reset.
    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R12
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(wr_en) && rd_a_idx == $past(wr_idx) && bank == $past(bank))
        |-> (rd_a_data == $past(wr_data)));

endmodule

// File: rtl/rbank_saved.sv
// One saved-status word per exception bank; the user bank has none.
// Assumes the bank input is stable between clock edges.
module rbank_saved
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             bank,
    input  logic              saved_wr_en,
    input  logic [DATA_W-1:0] saved_wr_data,
    output logic [DATA_W-1:0] saved_rd_data
);

    localparam int SIDX_W = $clog2(NUM_SAVED);

    logic [DATA_W-1:0] saved_q [NUM_SAVED];
    logic [SIDX_W-1:0] sidx;
    logic [2:0]        sdiff;

    // Word index of the current exception bank.
    always_comb begin
        sdiff = 3'(bank) - 3'(BK_FAST);
        sidx  = sdiff[SIDX_W-1:0];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SAVED; gi++) begin : g_word
            // Saved word gi: cleared on reset, loaded in its own bank only.
            always_ff @(posedge clk) begin
                if (!rst_n) saved_q[gi] <= '0;
                else if (saved_wr_en && bank != BK_USER && sidx == SIDX_W'(gi))
                    saved_q[gi] <= saved_wr_data;
            end
        end
    endgenerate

    // Read of the current bank's word, zero in the user bank.
    always_comb saved_rd_data = (bank == BK_USER) ? '0 : saved_q[sidx];

    logic live_q;
    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R7
    saved_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(saved_wr_en) && bank != BK_USER && bank == $past(bank))
        |-> (saved_rd_data == $past(saved_wr_data)));

    // R8
    saved_user_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BK_USER) |-> (saved_rd_data == '0));

endmodule

// File: rtl/rbank_file.sv
// Top of the mode-banked register file: mode register, general register
// banks and saved-status words. All writes use the mode held before the edge.
module rbank_file
    import rbank_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_REGS)-1:0] rd_a_idx,
    output logic [DATA_W-1:0]           rd_a_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_b_idx,
    output logic [DATA_W-1:0]           rd_b_data,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        mode_chg,
    input  logic [4:0]                  mode_new,
    output logic [4:0]                  mode_cur,
    input  logic                        saved_wr_en,
    input  logic [DATA_W-1:0]           saved_wr_data,
    output logic [DATA_W-1:0]           saved_rd_data
);

    bank_e bank;

    rbank_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_chg (mode_chg),
        .mode_new (mode_new),
        .mode_q   (mode_cur),
        .bank     (bank)
    );

    rbank_gpr #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank      (bank),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    rbank_saved #(
        .DATA_W (DATA_W)
    ) u_saved (
        .clk           (clk),
        .rst_n         (rst_n),
        .bank          (bank),
        .saved_wr_en   (saved_wr_en),
        .saved_wr_data (saved_wr_data),
        .saved_rd_data (saved_rd_data)
    );

endmodule

// File: tb/rbank_file_bench.sv
module rbank_file_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] M_USR = 5'h10;
    localparam logic [4:0] M_FST = 5'h11;
    localparam logic [4:0] M_IRQ = 5'h12;
    localparam logic [4:0] M_SUP = 5'h13;
    localparam logic [4:0] M_ABT = 5'h17;
    localparam logic [4:0] M_UND = 5'h1B;
    localparam logic [4:0] M_SYS = 5'h1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, saved_wr_data = '0, saved_rd_data;
    logic        wr_en = 1'b0, mode_chg = 1'b0, saved_wr_en = 1'b0;
    logic [4:0]  mode_new = '0, mode_cur;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbank_file u_rbank_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mode_chg(mode_chg), .mode_new(mode_new), .mode_cur(mode_cur),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data),
        .saved_rd_data(saved_rd_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic go_mode(input logic [4:0] m);
        mode_chg = 1'b1; mode_new = m;
        tick();
        mode_chg = 1'b0;
    endtask

    task automatic swr(input logic [31:0] d);
        saved_wr_en = 1'b1; saved_wr_data = d;
        tick();
        saved_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] i, input logic [31:0] exp);
        rd_a_idx = i;
        #1;
        chk(req, rd_a_data, exp);
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1 mode", 32'(mode_cur), 32'(M_SUP));
        for (int i = 0; i < 16; i++) rd_chk("R1 reg", 4'(i), 32'h0);
        chk("R1 saved", saved_rd_data, 32'h0);
        go_mode(M_FST);
        rd_chk("R1 fast reg", 4'd10, 32'h0);
        chk("R1 fast saved", saved_rd_data, 32'h0);
        go_mode(M_SUP);
    endtask

    // R3: low indices and 15 shared by every mode
    task automatic t_shared();
        for (int i = 0; i < 8; i++) wr(4'(i), 32'hA000_0000 + 32'(i));
        wr(4'd15, 32'hA000_000F);
        go_mode(M_FST);
        rd_chk("R3 fast r3", 4'd3, 32'hA000_0003);
        rd_chk("R3 fast r15", 4'd15, 32'hA000_000F);
        go_mode(M_ABT);
        rd_chk("R3 abort r7", 4'd7, 32'hA000_0007);
        go_mode(M_SUP);
    endtask

    // R4, R6, R11: fast copies of 8..14 and user/system sharing
    task automatic t_fast_user();
        go_mode(M_USR);
        for (int i = 8; i < 15; i++) wr(4'(i), 32'hB000_0000 + 32'(i));
        go_mode(M_FST);
        for (int i = 8; i < 15; i++) rd_chk("R4 fast init", 4'(i), 32'h0);
        for (int i = 8; i < 15; i++) wr(4'(i), 32'hF000_0000 + 32'(i));
        go_mode(M_SYS);
        rd_chk("R6 sys r9", 4'd9, 32'hB000_0009);
        rd_chk("R6 sys r13", 4'd13, 32'hB000_000D);
        wr(4'd14, 32'h5151_000E);
        go_mode(M_USR);
        rd_chk("R6 user r14", 4'd14, 32'h5151_000E);
        rd_chk("R4 user r8", 4'd8, 32'hB000_0008);
        go_mode(M_FST);
        rd_chk("R11 fast r8", 4'd8, 32'hF000_0008);
        rd_chk("R11 fast r14", 4'd14, 32'hF000_000E);
    endtask

    // R5, R11: per-exception-mode upper pair, 8..12 shared with user
    task automatic t_priv();
        logic [4:0] ml [4] = '{M_IRQ, M_SUP, M_ABT, M_UND};
        for (int k = 0; k < 4; k++) begin
            go_mode(ml[k]);
            wr(4'd13, {8'hC0, 19'd0, ml[k]});
            wr(4'd14, {8'hD0, 19'd0, ml[k]});
        end
        go_mode(M_IRQ);
        wr(4'd10, 32'hEEEE_000A);
        for (int k = 3; k >= 0; k--) begin
            go_mode(ml[k]);
            rd_chk("R5 r13", 4'd13, {8'hC0, 19'd0, ml[k]});
            rd_chk("R5 r14", 4'd14, {8'hD0, 19'd0, ml[k]});
            rd_chk("R5 r10 shared", 4'd10, 32'hEEEE_000A);
        end
        go_mode(M_USR);
        rd_chk("R5 user r10", 4'd10, 32'hEEEE_000A);
        rd_chk("R11 user r13", 4'd13, 32'hB000_000D);
    endtask

    // R7, R8: saved-status words
    task automatic t_saved();
        logic [4:0] ml [5] = '{M_FST, M_IRQ, M_SUP, M_ABT, M_UND};
        for (int k = 0; k < 5; k++) begin
            go_mode(ml[k]);
            swr({8'h5A, 19'd0, ml[k]});
        end
        go_mode(M_USR);
        chk("R8 user saved", saved_rd_data, 32'h0);
        swr(32'hDEAD_BEEF);
        chk("R8 user saved after wr", saved_rd_data, 32'h0);
        go_mode(M_SYS);
        swr(32'hBAD0_BAD0);
        chk("R8 sys saved", saved_rd_data, 32'h0);
        for (int k = 0; k < 5; k++) begin
            go_mode(ml[k]);
            chk("R7 saved word", saved_rd_data, {8'h5A, 19'd0, ml[k]});
        end
    endtask

    // R9: unlisted mode values select user copies
    task automatic t_invalid();
        go_mode(5'h05);
        chk("R9 mode held", 32'(mode_cur), 32'h05);
        rd_chk("R9 r13 as user", 4'd13, 32'hB000_000D);
        rd_chk("R9 r14 as user", 4'd14, 32'h5151_000E);
        chk("R9 saved zero", saved_rd_data, 32'h0);
        go_mode(5'h1C);
        rd_chk("R9 r8 as user", 4'd8, 32'hB000_0008);
    endtask

    // R10: write with mode change lands in old mode's copy
    task automatic t_same_cycle();
        go_mode(M_SUP);
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h1234_5678;
        saved_wr_en = 1'b1; saved_wr_data = 32'h8765_4321;
        mode_chg = 1'b1; mode_new = M_IRQ;
        tick();
        wr_en = 1'b0; saved_wr_en = 1'b0; mode_chg = 1'b0;
        chk("R2 mode switched", 32'(mode_cur), 32'(M_IRQ));
        rd_chk("R10 new mode r13", 4'd13, {8'hC0, 19'd0, M_IRQ});
        chk("R10 new mode saved", saved_rd_data, {8'h5A, 19'd0, M_IRQ});
        go_mode(M_SUP);
        rd_chk("R10 old mode r13", 4'd13, 32'h1234_5678);
        chk("R10 old mode saved", saved_rd_data, 32'h8765_4321);
    endtask

    // R12, R2: dual reads, write visible only after the edge
    task automatic t_ports();
        @(negedge clk);
        rd_a_idx = 4'd2; rd_b_idx = 4'd5;
        #1;
        chk("R12 port a", rd_a_data, 32'hA000_0002);
        chk("R12 port b", rd_b_data, 32'hA000_0005);
        wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h7777_0002;
        #1;
        chk("R12 before edge", rd_a_data, 32'hA000_0002);
        tick();
        wr_en = 1'b0;
        chk("R12 after edge", rd_a_data, 32'h7777_0002);
        chk("R12 port b steady", rd_b_data, 32'hA000_0005);
        mode_new = M_FST;
        tick();
        chk("R2 no request holds", 32'(mode_cur), 32'(M_SUP));
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_shared();
        t_fast_user();
        t_priv();
        t_saved();
        t_invalid();
        t_same_cycle();
        t_ports();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule